// File: doc/BRIEF.md
# Retire-Counted Interrupt Hold-Off Gate

This block sits beside an in-order retire stage and turns an instruction modifier into a short window during which maskable interrupts are held back. The modifier supplies a small count. From the next cycle on, each retire group lowers the remaining count by the number of instructions in that group. The window ends only when a whole group has brought the count to zero. Because the window can close only at a group boundary, the protected span is never shorter than the count requested.

A maskable request that arrives while the window is open is not lost. It is remembered and is taken in the first cycle after the window has closed. A non-maskable request bypasses the window and is taken in the cycle it is raised. The count is clamped to a hard ceiling, so software cannot block interrupts for long. A modifier that arrives while a window is already open can only lengthen it, up to that ceiling.

Top module: `retire_irq_gate`

## Requirements
- R1: While synchronous active-high `rst` is high and in the cycle after it, `hold_active` is 0 and any remembered maskable request is discarded. The first maskable request after reset is taken in the same cycle it is raised.
- R2: A modifier with a non-zero count (`mod_valid`=1) makes `hold_active` 1 in the next cycle.
- R3: Each cycle with `ret_valid`=1 lowers the remaining count by `ret_size`. A cycle with `ret_valid`=0 leaves the count unchanged. `hold_active` goes to 0 in the cycle after the group that brings the count to zero.
- R4: A group larger than the remaining count saturates the count at zero, so the window closes after that whole group.
- R5: A modifier count above 8 (`mod_count` is 4 bits) acts as 8.
- R6: A modifier loads the larger of two values: the clamped new count, and the remaining count after that same cycle's retire group. The group that retires in the modifier's own cycle never consumes the new count.
- R7: While `hold_active` is 1, `irq_take` is 0. A maskable request seen during the window is held, and `irq_take` rises in the first cycle with `hold_active`=0, even if `irq_req` has since fallen. The held request is cleared once it is taken.
- R8: `nmi_take` equals `nmi_req` in every cycle, whether or not a window is open. While `nmi_req` is 1, `irq_take` is 0 and any maskable request stays held.
- R9: A modifier with count 0 opens no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_valid | input | 1 | Hold-off modifier retired this cycle |
| mod_count | input | 4 | Requested instruction count of the modifier |
| ret_valid | input | 1 | A retire group completes this cycle |
| ret_size | input | 3 | Number of instructions in the retire group (1 to 4) |
| irq_req | input | 1 | Maskable interrupt request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| irq_take | output | 1 | Take the maskable interrupt now |
| nmi_take | output | 1 | Take the non-maskable interrupt now |
| hold_active | output | 1 | Hold-off window is open |

## Verification
A wrong remaining count appears at the ports as `hold_active` falling one group too early or too late. A held maskable request that is deferred then shows `irq_take` rising in the wrong cycle. A lost pending flag shows as no `irq_take` at all after the window closes. Every such fault is visible within one cycle of the retire group that should have closed the window. The directed cases therefore place their checks in the cycle right after each closing group, and in the cycles on either side of each modifier.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

    // Which interrupt, if any, the gate grants this cycle.
    typedef enum logic [1:0] {
        TAKE_NONE     = 2'd0,
        TAKE_MASKABLE = 2'd1,
        TAKE_NMI      = 2'd2
    } take_e;

endpackage

// File: rtl/hold_count_next.sv
module hold_count_next #(
    parameter int unsigned CNT_W    = 4,
    parameter int unsigned GRP_W    = 3,
    parameter int unsigned MAX_HOLD = 8,
    parameter int unsigned REM_W    = 4
) (
    input  logic [REM_W-1:0] rem_q,
    input  logic             ret_valid,
    input  logic [GRP_W-1:0] ret_size,
    input  logic             mod_valid,
    input  logic [CNT_W-1:0] mod_count,
    output logic [REM_W-1:0] rem_d
);
    localparam int unsigned WIDE = REM_W + CNT_W + GRP_W;

    logic [WIDE-1:0] rem_w;
    logic [WIDE-1:0] size_w;
    logic [WIDE-1:0] req_w;
    logic [WIDE-1:0] ceil_w;
    logic [WIDE-1:0] after_w;
    logic [WIDE-1:0] load_w;
    logic [WIDE-1:0] next_w;

    always_comb begin
        rem_w  = WIDE'(rem_q);
        size_w = ret_valid ? WIDE'(ret_size) : '0;
        req_w  = WIDE'(mod_count);
        ceil_w = WIDE'(MAX_HOLD);

        // Drain by the whole group, stopping at zero.
        after_w = (size_w >= rem_w) ? '0 : (rem_w - size_w);

        // Clamp the requested count to the ceiling.
        load_w = (req_w > ceil_w) ? ceil_w : req_w;

        // A new request can only lengthen the window.
        if (mod_valid && (load_w > after_w)) begin
            next_w = load_w;
        end else begin
            next_w = after_w;
        end

        rem_d = REM_W'(next_w);
    end
endmodule

// File: rtl/irq_take_arb.sv
module irq_take_arb
    import irq_gate_pkg::*;
(
    input  logic  irq_req,
    input  logic  nmi_req,
    input  logic  pend_q,
    input  logic  hold_open,
    output take_e take,
    output logic  pend_d
);
    logic want_irq;

    always_comb begin
        want_irq = irq_req | pend_q;
        if (nmi_req) begin
            take = TAKE_NMI;
        end else if (want_irq && !hold_open) begin
            take = TAKE_MASKABLE;
        end else begin
            take = TAKE_NONE;
        end
        pend_d = want_irq && (take != TAKE_MASKABLE);
    end
endmodule

// File: rtl/retire_irq_gate.sv
module retire_irq_gate
    import irq_gate_pkg::*;
#(
    parameter int unsigned CNT_W    = 4,
    parameter int unsigned GRP_W    = 3,
    parameter int unsigned MAX_HOLD = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mod_valid,
    input  logic [CNT_W-1:0] mod_count,
    input  logic             ret_valid,
    input  logic [GRP_W-1:0] ret_size,
    input  logic             irq_req,
    input  logic             nmi_req,
    output logic             irq_take,
    output logic             nmi_take,
    output logic             hold_active
);
    localparam int unsigned REM_W = $clog2(MAX_HOLD + 1);

    typedef struct packed {
        logic [REM_W-1:0] rem;
        logic             pend;
    } gate_state_t;

    gate_state_t st_d;
    gate_state_t st_q;

    logic [REM_W-1:0] rem_next;
    logic             pend_next;
    take_e            take;

    generate
        if (MAX_HOLD == 0) begin : g_bad_ceiling
            initial $error("MAX_HOLD must be non-zero");
        end
    endgenerate

    hold_count_next #(
        .CNT_W    (CNT_W),
        .GRP_W    (GRP_W),
        .MAX_HOLD (MAX_HOLD),
        .REM_W    (REM_W)
    ) count_i (
        .rem_q     (st_q.rem),
        .ret_valid (ret_valid),
        .ret_size  (ret_size),
        .mod_valid (mod_valid),
        .mod_count (mod_count),
        .rem_d     (rem_next)
    );

    irq_take_arb arb_i (
        .irq_req   (irq_req),
        .nmi_req   (nmi_req),
        .pend_q    (st_q.pend),
        .hold_open (hold_active),
        .take      (take),
        .pend_d    (pend_next)
    );

    always_comb begin
        st_d.rem  = rem_next;
        st_d.pend = pend_next;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_active = (st_q.rem != '0);
    assign irq_take    = (take == TAKE_MASKABLE);
    assign nmi_take    = (take == TAKE_NMI);
endmodule

// File: rtl/retire_irq_gate_chk.sv
module retire_irq_gate_chk #(
    parameter int unsigned CNT_W    = 4,
    parameter int unsigned MAX_HOLD = 8,
    parameter int unsigned REM_W    = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             mod_valid,
    input logic [CNT_W-1:0] mod_count,
    input logic             irq_req,
    input logic             nmi_req,
    input logic             irq_take,
    input logic             nmi_take,
    input logic             hold_active,
    input logic [REM_W-1:0] rem_q,
    input logic             pend_q
);
    assert_reset_closes_R1: assert property (@(posedge clk)
        rst |=> (!hold_active && !pend_q));

    assert_opens_window_R2: assert property (@(posedge clk) disable iff (rst)
        (mod_valid && mod_count != '0) |=> hold_active);

    assert_count_ceiling_R5: assert property (@(posedge clk) disable iff (rst)
        rem_q <= REM_W'(MAX_HOLD));

    assert_no_irq_in_window_R7: assert property (@(posedge clk) disable iff (rst)
        hold_active |-> !irq_take);

    assert_pending_kept_R7: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !irq_take) |=> pend_q);

    assert_nmi_passes_R8: assert property (@(posedge clk) disable iff (rst)
        nmi_req |-> (nmi_take && !irq_take));

    assert_zero_count_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (mod_valid && mod_count == '0 && !hold_active) |=> !hold_active);
endmodule

bind retire_irq_gate retire_irq_gate_chk #(
    .CNT_W    (CNT_W),
    .MAX_HOLD (MAX_HOLD),
    .REM_W    (REM_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .mod_valid   (mod_valid),
    .mod_count   (mod_count),
    .irq_req     (irq_req),
    .nmi_req     (nmi_req),
    .irq_take    (irq_take),
    .nmi_take    (nmi_take),
    .hold_active (hold_active),
    .rem_q       (st_q.rem),
    .pend_q      (st_q.pend)
);

// File: tb/retire_irq_gate_tb_top.sv
module retire_irq_gate_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mod_valid = 1'b0;
    logic [3:0] mod_count = '0;
    logic       ret_valid = 1'b0;
    logic [2:0] ret_size = '0;
    logic       irq_req = 1'b0;
    logic       nmi_req = 1'b0;
    logic       irq_take;
    logic       nmi_take;
    logic       hold_active;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    retire_irq_gate dut_i (
        .clk         (clk),
        .rst         (rst),
        .mod_valid   (mod_valid),
        .mod_count   (mod_count),
        .ret_valid   (ret_valid),
        .ret_size    (ret_size),
        .irq_req     (irq_req),
        .nmi_req     (nmi_req),
        .irq_take    (irq_take),
        .nmi_take    (nmi_take),
        .hold_active (hold_active)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one cycle's inputs at the falling edge, settle, then sample.
    task automatic apply(input logic mv, input int mc, input logic rv, input int rs,
                         input logic ir, input logic nr);
        mod_valid = mv;
        mod_count = 4'(mc);
        ret_valid = rv;
        ret_size  = 3'(rs);
        irq_req   = ir;
        nmi_req   = nr;
        #2;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        apply(0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_reset();
        idle();
        chk("R1 window closed after reset", hold_active, 0);
        chk("R1 no stray take", irq_take, 0);
        apply(0, 0, 0, 0, 1, 0);
        chk("R1 first irq taken at once", irq_take, 1);
        tick(); idle();
        chk("R1 taken irq not repeated", irq_take, 0);
        // Reset in the middle of a window with a held request.
        apply(1, 8, 0, 0, 0, 0); tick();
        apply(0, 0, 0, 0, 1, 0); tick();
        rst = 1'b1; idle(); tick(); rst = 1'b0; idle();
        chk("R1 reset closes open window", hold_active, 0);
        chk("R1 reset drops held irq", irq_take, 0);
    endtask

    task automatic t_basic();
        apply(1, 6, 0, 0, 0, 0); tick(); idle();
        chk("R2 window opens next cycle", hold_active, 1);
        apply(0, 0, 1, 2, 0, 0); tick(); idle();
        chk("R3 open after 2 of 6", hold_active, 1);
        tick(); idle();
        chk("R3 idle cycle keeps count", hold_active, 1);
        apply(0, 0, 1, 2, 0, 0); tick(); idle();
        chk("R3 open after 4 of 6", hold_active, 1);
        apply(0, 0, 1, 2, 0, 0); tick(); idle();
        chk("R3 closes after 6 of 6", hold_active, 0);
    endtask

    task automatic t_overshoot();
        apply(1, 5, 0, 0, 0, 0); tick();
        apply(0, 0, 1, 3, 0, 0); tick(); idle();
        chk("R4 open with 2 left", hold_active, 1);
        apply(0, 0, 1, 3, 0, 0); tick(); idle();
        chk("R4 group overshoot closes", hold_active, 0);
    endtask

    task automatic t_clamp();
        apply(1, 15, 0, 0, 0, 0); tick();
        apply(0, 0, 1, 4, 0, 0); tick(); idle();
        chk("R5 open after 4 of clamped 8", hold_active, 1);
        apply(0, 0, 1, 4, 0, 0); tick(); idle();
        chk("R5 count 15 acts as 8", hold_active, 0);
    endtask

    task automatic t_merge();
        apply(1, 6, 0, 0, 0, 0); tick();
        apply(0, 0, 1, 4, 0, 0); tick();
        apply(1, 3, 0, 0, 0, 0); tick();
        apply(0, 0, 1, 2, 0, 0); tick(); idle();
        chk("R6 larger new count extends", hold_active, 1);
        apply(0, 0, 1, 1, 0, 0); tick(); idle();
        chk("R6 extended window closes", hold_active, 0);

        apply(1, 8, 0, 0, 0, 0); tick();
        apply(0, 0, 1, 1, 0, 0); tick();
        apply(1, 2, 0, 0, 0, 0); tick();
        apply(0, 0, 1, 4, 0, 0); tick(); idle();
        chk("R6 smaller new count ignored", hold_active, 1);
        apply(0, 0, 1, 3, 0, 0); tick(); idle();
        chk("R6 original window closes", hold_active, 0);

        apply(1, 4, 1, 4, 0, 0); tick(); idle();
        chk("R6 same-cycle group spares new count", hold_active, 1);
        apply(0, 0, 1, 4, 0, 0); tick(); idle();
        chk("R6 window closes after 4", hold_active, 0);
    endtask

    task automatic t_defer();
        apply(1, 4, 0, 0, 0, 0); tick();
        apply(0, 0, 0, 0, 1, 0);
        chk("R7 irq blocked in window", irq_take, 0);
        tick(); idle();
        chk("R7 held irq still blocked", irq_take, 0);
        apply(0, 0, 1, 4, 0, 0);
        chk("R7 blocked during closing group", irq_take, 0);
        tick(); idle();
        chk("R7 window closed", hold_active, 0);
        chk("R7 held irq taken after close", irq_take, 1);
        tick(); idle();
        chk("R7 held irq cleared once taken", irq_take, 0);
    endtask

    task automatic t_nmi();
        apply(1, 4, 0, 0, 0, 0); tick();
        apply(0, 0, 0, 0, 1, 1);
        chk("R8 nmi taken inside window", nmi_take, 1);
        chk("R8 irq not taken with nmi", irq_take, 0);
        tick();
        apply(0, 0, 1, 4, 0, 0);
        chk("R8 nmi take follows request", nmi_take, 0);
        tick();
        apply(0, 0, 0, 0, 0, 1);
        chk("R8 nmi wins over held irq", nmi_take, 1);
        chk("R8 held irq waits for nmi", irq_take, 0);
        tick(); idle();
        chk("R8 held irq taken after nmi", irq_take, 1);
        tick(); idle();
    endtask

    task automatic t_zero();
        apply(1, 0, 0, 0, 0, 0); tick(); idle();
        chk("R9 zero count opens nothing", hold_active, 0);
        apply(0, 0, 0, 0, 1, 0);
        chk("R9 irq taken after zero count", irq_take, 1);
        tick(); idle();
    endtask

    initial begin : watchdog
        #2000000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_overshoot();
        t_clamp();
        t_merge();
        t_defer();
        t_nmi();
        t_zero();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule